// File: doc/BRIEF.md
# Push-Pull PWM Controller with Deadtime

This block is a fixed-frequency digital pulse width modulator for switching power stages. A free-running ramp counter climbs from zero to a programmable terminal count and then wraps. On every wrap the block takes a new set of control words. Two error words are merged by keeping the larger one, and that value becomes the feedback level. A deadtime word is also sampled, and a minimum-deadtime offset derived from the terminal count is added to it. During a ramp cycle, a drive output may be on only while the ramp is above both levels. A larger control word therefore gives a shorter pulse.

A steering toggle flips on each wrap. In push-pull mode, successive pulses go to drive A and drive B in turn, so each output switches at half the ramp rate. In single-ended mode the toggle holds, and both outputs carry the same pulse on every cycle. A lockout flag forces both outputs off. In slave mode an external sync pulse wraps the ramp in place of the terminal count, so several controllers can share one ramp.

All pins are plain level control and status signals. There is no streamed data path, so no valid/ready handshake and no back-pressure apply. All outputs are registered.

Top module: `pp_pwm_ctrl`

## Requirements
- R1: A drive output is high in the cycle after the ramp holds a value k only if k is strictly above the sampled feedback level and k is below the terminal count. A larger feedback word gives a proportionally shorter pulse.
- R2: The feedback level is the larger of `err_a` and `err_b`, so the input that asks for the least on-time sets the width.
- R3: Outputs are also held off while k is at or below the sampled deadtime word plus an offset equal to ceil(terminal_count / 25). This blocks roughly the first 4% of every cycle, even when the deadtime word is zero.
- R4: In master mode the ramp runs 0..`term_cnt`, one cycle per count, giving a period of `term_cnt`+1 cycles. `wrap_strobe` is high for exactly one cycle per period (while the ramp is 0), and both drives are low in that cycle.
- R5: With `push_pull`=1, pulses go to `drv_a` and `drv_b` on alternate ramp periods, and the two drives are never high together.
- R6: With `push_pull`=0, the toggle is held and `drv_a` and `drv_b` carry the same pulse in every period.
- R7: `term_cnt`, `err_a`, `err_b` and `dead_word` are sampled only at a ramp wrap. A change in the middle of a period does not alter that period's pulse.
- R8: While `lockout` is high, both drives are low from the next cycle on.
- R9: A feedback or deadtime word at or above the terminal count gives zero duty, with no glitch pulse.
- R10: With `slave_en`=1, a one-cycle `sync_in` pulse wraps the ramp, and the terminal count no longer sets the period.
- R11: While `rst_n` is low, the ramp and toggle are cleared and `drv_a`, `drv_b` and `wrap_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| term_cnt | input | CW | Ramp terminal count (period minus one) |
| err_a | input | CW | First error word |
| err_b | input | CW | Second error word |
| dead_word | input | CW | Extra deadtime level |
| push_pull | input | 1 | 1 = alternate outputs, 0 = both outputs together |
| lockout | input | 1 | Forces both drives off |
| slave_en | input | 1 | Ramp wraps on `sync_in` instead of terminal count |
| sync_in | input | 1 | External ramp reset pulse |
| drv_a | output | 1 | Drive enable A |
| drv_b | output | 1 | Drive enable B |
| wrap_strobe | output | 1 | One-cycle pulse marking ramp restart |

## Verification
The outputs show internal faults within one or two ramp periods. A ramp that mis-counts shows up as a wrong spacing between strobes. A bad offset or a wrong comparison shows up as a per-period high count on the drives that is off by a few cycles. A steering toggle that is stuck or flips freely shows up as the two push-pull outputs failing to alternate. Mid-period sampling would change the pulse count within the same period in which a word changes.

// File: rtl/pp_pwm_pkg.sv
package pp_pwm_pkg;
  typedef enum logic {
    MODE_SINGLE   = 1'b0,
    MODE_PUSHPULL = 1'b1
  } drive_mode_e;

  localparam int unsigned OFFS_DIV_DEF = 25;
  localparam int unsigned NUM_DRV = 2;
endpackage

// File: rtl/pp_ramp_counter.sv
module pp_ramp_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_en,
  input  logic          sync_in,
  input  logic [CW-1:0] tc_q,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          wrap_strobe
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  assign wrap = slave_en ? sync_in : (cnt >= tc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      wrap_strobe <= 1'b0;
    end else begin
      wrap_strobe <= wrap;
      if (wrap)
        cnt <= '0;
      else if (cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end

  // R4: in master mode the ramp never climbs past the sampled terminal count
  p_cnt_bound_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_en && $past(!slave_en) && $past(cnt <= tc_q)) |-> (cnt <= tc_q));

  // R10: a sync pulse in slave mode restarts the ramp
  p_sync_wrap_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slave_en) && $past(sync_in)) |-> (cnt == '0));
endmodule

// File: rtl/pp_ctrl_sampler.sv
module pp_ctrl_sampler #(
  parameter int          CW       = 8,
  parameter int unsigned OFFS_DIV = 25,
  localparam int         EW       = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrap,
  input  logic [CW-1:0] term_cnt,
  input  logic [CW-1:0] err_a,
  input  logic [CW-1:0] err_b,
  input  logic [CW-1:0] dead_word,
  output logic [CW-1:0] tc_q,
  output logic [CW-1:0] fb_q,
  output logic [EW-1:0] lim_q
);
  logic [CW-1:0] fb_next;
  logic [EW-1:0] offs_next;
  logic [EW-1:0] lim_next;

  always_comb begin
    fb_next   = (err_a >= err_b) ? err_a : err_b;
    offs_next = ({1'b0, term_cnt} + EW'(OFFS_DIV - 1)) / EW'(OFFS_DIV);
    lim_next  = {1'b0, dead_word} + offs_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q  <= '1;
      fb_q  <= '1;
      lim_q <= '1;
    end else if (wrap) begin
      tc_q  <= term_cnt;
      fb_q  <= fb_next;
      lim_q <= lim_next;
    end
  end

  // R7: sampled words hold between wraps
  p_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wrap) |-> ($stable(fb_q) && $stable(lim_q) && $stable(tc_q)));
endmodule

// File: rtl/pp_pulse_steer.sv
module pp_pulse_steer #(
  parameter int CW = 8,
  localparam int EW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          wrap,
  input  logic [CW-1:0] fb_q,
  input  logic [EW-1:0] lim_q,
  input  logic          push_pull,
  input  logic          lockout,
  output logic [pp_pwm_pkg::NUM_DRV-1:0] drv
);
  import pp_pwm_pkg::*;

  logic        tgl;
  logic        pulse_on;
  drive_mode_e mode;

  assign mode     = drive_mode_e'(push_pull);
  assign pulse_on = (cnt > fb_q) && ({1'b0, cnt} > lim_q) && !wrap && !lockout;

  always_ff @(posedge clk) begin
    if (!rst_n)
      tgl <= 1'b0;
    else if (wrap && mode == MODE_PUSHPULL)
      tgl <= ~tgl;
  end

  for (genvar gi = 0; gi < NUM_DRV; gi++) begin : g_drv
    logic sel;
    assign sel = (mode == MODE_SINGLE) || (tgl == gi[0]);
    always_ff @(posedge clk) begin
      if (!rst_n)
        drv[gi] <= 1'b0;
      else
        drv[gi] <= pulse_on && sel;
    end
  end

  // R6: single-ended mode holds the steering toggle
  p_tgl_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(!push_pull) |-> $stable(tgl));

  // R8: lockout silences both drives on the next cycle
  p_lock_off_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(lockout) |-> (drv == '0));

  // R3: nothing drives while the ramp sits at or below the deadtime limit
  p_dead_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    $past({1'b0, cnt} <= lim_q) |-> (drv == '0));
endmodule

// File: rtl/pp_pwm_ctrl.sv
module pp_pwm_ctrl #(
  parameter int          CW       = 8,
  parameter int unsigned OFFS_DIV = pp_pwm_pkg::OFFS_DIV_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] term_cnt,
  input  logic [CW-1:0] err_a,
  input  logic [CW-1:0] err_b,
  input  logic [CW-1:0] dead_word,
  input  logic          push_pull,
  input  logic          lockout,
  input  logic          slave_en,
  input  logic          sync_in,
  output logic          drv_a,
  output logic          drv_b,
  output logic          wrap_strobe
);
  localparam int EW = CW + 1;

  logic [CW-1:0] cnt;
  logic          wrap;
  logic [CW-1:0] tc_q;
  logic [CW-1:0] fb_q;
  logic [EW-1:0] lim_q;
  logic [pp_pwm_pkg::NUM_DRV-1:0] drv;

  pp_ramp_counter #(.CW(CW)) u_ramp (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .sync_in(sync_in),
    .tc_q(tc_q), .cnt(cnt), .wrap(wrap), .wrap_strobe(wrap_strobe)
  );

  pp_ctrl_sampler #(.CW(CW), .OFFS_DIV(OFFS_DIV)) u_samp (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .term_cnt(term_cnt),
    .err_a(err_a), .err_b(err_b), .dead_word(dead_word),
    .tc_q(tc_q), .fb_q(fb_q), .lim_q(lim_q)
  );

  pp_pulse_steer #(.CW(CW)) u_steer (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap), .fb_q(fb_q),
    .lim_q(lim_q), .push_pull(push_pull), .lockout(lockout), .drv(drv)
  );

  assign drv_a = drv[0];
  assign drv_b = drv[1];

  // R4: the restart cycle carries no drive
  p_wrap_off_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    wrap_strobe |-> (!drv_a && !drv_b));

  // R5: push-pull never drives both sides at once
  p_excl_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(push_pull) |-> !(drv_a && drv_b));

  // R6: single-ended outputs match
  p_same_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(!push_pull) |-> (drv_a == drv_b));
endmodule

// File: tb/pp_pwm_ctrl_bench.sv
`timescale 1ns/1ps
module pp_pwm_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] term_cnt = 8'd99, err_a = '0, err_b = '0, dead_word = '0;
  logic       push_pull = 1'b0, lockout = 1'b0, slave_en = 1'b0, sync_in = 1'b0;
  logic       drv_a, drv_b, wrap_strobe;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pp_pwm_ctrl u_pp_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .term_cnt(term_cnt), .err_a(err_a), .err_b(err_b),
    .dead_word(dead_word), .push_pull(push_pull), .lockout(lockout),
    .slave_en(slave_en), .sync_in(sync_in), .drv_a(drv_a), .drv_b(drv_b),
    .wrap_strobe(wrap_strobe)
  );

  typedef struct packed {
    logic [7:0]  tc;
    logic [7:0]  ea;
    logic [7:0]  eb;
    logic [7:0]  dt;
    logic        pp;
    logic [15:0] exp_a;
    logic [15:0] exp_b;
  } vec_t;

  // Expected high counts over two ramp periods
  localparam vec_t VECS [0:9] = '{
    '{8'd99,  8'd0,  8'd0,  8'd0,   1'b0, 16'd188, 16'd188},
    '{8'd99,  8'd0,  8'd0,  8'd0,   1'b1, 16'd94,  16'd94 },
    '{8'd99,  8'd50, 8'd20, 8'd0,   1'b0, 16'd96,  16'd96 },
    '{8'd99,  8'd20, 8'd60, 8'd0,   1'b1, 16'd38,  16'd38 },
    '{8'd99,  8'd0,  8'd0,  8'd30,  1'b0, 16'd128, 16'd128},
    '{8'd99,  8'd99, 8'd0,  8'd0,   1'b0, 16'd0,   16'd0  },
    '{8'd49,  8'd0,  8'd0,  8'd0,   1'b0, 16'd92,  16'd92 },
    '{8'd200, 8'd10, 8'd0,  8'd0,   1'b1, 16'd189, 16'd189},
    '{8'd200, 8'd0,  8'd0,  8'd250, 1'b1, 16'd0,   16'd0  },
    '{8'd255, 8'd0,  8'd0,  8'd0,   1'b0, 16'd486, 16'd486}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!wrap_strobe);
  endtask

  task automatic measure(input int n, output int ca, output int cb);
    ca = 0; cb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca += int'(drv_a);
      cb += int'(drv_b);
    end
  endtask

  initial begin
    #750000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ca, cb, ca2, cb2;
    // R11 reset state
    repeat (5) @(negedge clk);
    chk("R11 drv_a in reset", int'(drv_a), 0);
    chk("R11 drv_b in reset", int'(drv_b), 0);
    chk("R11 strobe in reset", int'(wrap_strobe), 0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R5 R6 R9
    for (int v = 0; v < 10; v++) begin
      term_cnt = VECS[v].tc; err_a = VECS[v].ea; err_b = VECS[v].eb;
      dead_word = VECS[v].dt; push_pull = VECS[v].pp;
      wait_strobe(); wait_strobe();
      measure(2 * (int'(VECS[v].tc) + 1), ca, cb);
      chk($sformatf("R1 R2 R3 R9 vec %0d drv_a", v), ca, int'(VECS[v].exp_a));
      chk($sformatf("R5 R6 vec %0d drv_b", v), cb, int'(VECS[v].exp_b));
    end

    // R4 strobe spacing
    term_cnt = 8'd99; err_a = '0; err_b = '0; dead_word = '0; push_pull = 1'b0;
    wait_strobe(); wait_strobe();
    begin
      int gap = 0;
      do begin @(negedge clk); gap++; end while (!wrap_strobe);
      chk("R4 strobe period", gap, 100);
    end

    // R5 alternation across consecutive periods
    push_pull = 1'b1;
    wait_strobe(); wait_strobe();
    measure(100, ca, cb);
    measure(100, ca2, cb2);
    chk("R5 one side per period", ca + cb, 94);
    chk("R5 sides swap a", ca2, cb);
    chk("R5 sides swap b", cb2, ca);

    // R7 mid-period change has no effect until the next wrap
    push_pull = 1'b0;
    wait_strobe(); wait_strobe();
    ca = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      ca += int'(drv_a);
      if (i == 10) err_a = 8'd80;
    end
    chk("R7 period after mid change", ca, 94);
    measure(100, ca, cb);
    chk("R7 next period uses new word", ca, 18);
    err_a = '0;

    // R8 lockout
    lockout = 1'b1;
    wait_strobe();
    measure(100, ca, cb);
    chk("R8 lockout drv_a", ca, 0);
    chk("R8 lockout drv_b", cb, 0);
    lockout = 1'b0;

    // R10 slave sync
    slave_en = 1'b1;
    begin
      int last = -1, iv = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (wrap_strobe) begin
          if (last >= 0) iv = i - last;
          last = i;
        end
        sync_in = (i % 60 == 0);
      end
      chk("R10 sync period", iv, 60);
    end
    slave_en = 1'b0; sync_in = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule